// File: doc/BRIEF.md
# Read Latency and Byte-Mask Data Pipeline

This block is the data-side timing path of a synchronous DRAM device model. Every read beat the array delivers is given to it as a one-cycle issue pulse together with the read word. The block holds the beat for the number of clocks set by the programmed read latency and then drives it on the data output with a per-byte output enable. Both read latencies are 2 and 3 clocks. The output enable travels through the same shift register as the data, so a new beat can enter on every clock.

Two byte-mask bits act on the data path at different delays. On the read side, a mask bit removes its byte from the output two clocks after it is seen. On the write side, it blocks the byte's write strobe in the same clock. A precharge command stops the stream: the slot CL clocks after the precharge stays empty. A latency code that names no supported latency raises an error flag, empties the pipeline and keeps all bytes disabled.

Top module: `sdr_rdpath`

## Requirements
- R1: The 3-bit latency code selects latency 2 when it is 3'b010 and latency 3 when it is 3'b011. Every other code is reserved, and `lat_err` is high in the same cycle as such a code.
- R2: Take a read issued in cycle n with a supported latency L, no precharge and no mask. In cycle n+L both bits of `dq_oe` are high and `dq_out` equals that read word.
- R3: Reads issued on consecutive cycles appear on consecutive output cycles in issue order, with no gap and no repeated word.
- R4: A mask bit high in cycle m clears that lane's `dq_oe` bit in cycle m+2 only. Bit 0 masks lane 0 (`dq_out[7:0]`) and bit 1 masks lane 1 (`dq_out[15:8]`). The other lane is not affected.
- R5: `wr_lane_we[b]` is high exactly when `wr_beat` is high and mask bit b is low in the same cycle.
- R6: A precharge in cycle p discards any read issued in the same cycle. Reads issued before p still complete, and output slot p+L stays disabled unless a later read fills it.
- R7: While the code is reserved, `dq_oe` is all zero and reads are discarded. Each cycle spent with a reserved code also clears every read in flight, so none of them appears after a supported code returns.
- R8: Each lane whose `dq_oe` bit is low drives zero on its 8 bits of `dq_out`.
- R9: During reset and in the first cycle after it, `dq_oe` and `dq_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lat_code | input | 3 | Programmed read latency code |
| rd_issue | input | 1 | One read beat enters this cycle |
| rd_word | input | 16 | Read word for the beat issued this cycle |
| pre_cmd | input | 1 | Precharge command this cycle |
| dqm | input | 2 | Byte mask, bit b for lane b |
| wr_beat | input | 1 | A write data beat is present this cycle |
| dq_out | output | 16 | Delayed read data, zero on disabled lanes |
| dq_oe | output | 2 | Per-lane output enable |
| wr_lane_we | output | 2 | Per-lane write strobe for the current write beat |
| lat_err | output | 1 | Latency code is reserved |

## Verification
The assertions check on every cycle the properties that can be stated locally:
- a byte masked two clocks earlier is never enabled;
- no enable appears without a read loaded exactly L clocks before;
- a disabled lane drives zero;
- a reserved code leaves all lanes dark;
- no write strobe is high on a masked lane or without a write beat.

Other behaviour can only be shown by the bench's scenarios against its cycle model:
- that each word comes out in the right slot with the right value;
- that back-to-back reads keep their order;
- that the precharge cut lands at p+2 or p+3 depending on latency;
- that a reserved code really flushes reads in flight.

// File: rtl/sdr_rdpath_pkg.sv
package sdr_rdpath_pkg;
  localparam int LAT_CODE_W = 3;

  // Supported latencies are encoded as their own value in the code field.
  function automatic logic code_supported(input logic [LAT_CODE_W-1:0] code,
                                          input int min_lat, input int max_lat);
    return (int'(code) >= min_lat) && (int'(code) <= max_lat);
  endfunction
endpackage

// File: rtl/lat_decode.sv
module lat_decode
  import sdr_rdpath_pkg::*;
#(
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3,
  parameter int IDX_W   = 2
) (
  input  logic [LAT_CODE_W-1:0] code,
  output logic                  lat_ok,
  output logic [IDX_W-1:0]      tap_sel
);
  always_comb begin
    lat_ok  = code_supported(code, MIN_LAT, MAX_LAT);
    tap_sel = '0;
    if (lat_ok) begin
      tap_sel = IDX_W'(code - LAT_CODE_W'(1));
    end
  end
endmodule

// File: rtl/rd_shift_pipe.sv
module rd_shift_pipe #(
  parameter int DEPTH = 3,
  parameter int DW    = 16,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             flush,
  input  logic [DW-1:0]    din,
  input  logic [IDX_W-1:0] tap_sel,
  output logic             out_vld,
  output logic [DW-1:0]    out_data
);
  logic [DEPTH-1:0] vld_q, vld_d, dat_en;
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DW-1:0]    dat_d [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_comb begin
        vld_d[s]  = load & ~flush;
        dat_en[s] = load;
        dat_d[s]  = din;
      end
    end else begin : g_body
      always_comb begin
        vld_d[s]  = vld_q[s-1] & ~flush;
        dat_en[s] = vld_q[s-1];
        dat_d[s]  = dat_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end else begin
        vld_q[s] <= vld_d[s];
        if (dat_en[s]) begin
          dat_q[s] <= dat_d[s];
        end
      end
    end
  end

  always_comb begin
    out_vld  = 1'b0;
    out_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tap_sel == IDX_W'(i)) begin
        out_vld  = vld_q[i];
        out_data = dat_q[i];
      end
    end
  end
endmodule

// File: rtl/lane_mask.sv
module lane_mask #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                     rd_vld,
  input  logic [LANES*LANE_W-1:0]  rd_data,
  input  logic [LANES-1:0]         dqm_late,
  input  logic                     wr_beat,
  input  logic [LANES-1:0]         dqm_now,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic [LANES-1:0]         dq_oe,
  output logic [LANES-1:0]         wr_lane_we
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      dq_oe[b]                  = rd_vld & ~dqm_late[b];
      dq_out[b*LANE_W +: LANE_W] = dq_oe[b] ? rd_data[b*LANE_W +: LANE_W] : '0;
      wr_lane_we[b]             = wr_beat & ~dqm_now[b];
    end
  end
endmodule

// File: rtl/sdr_rdpath.sv
module sdr_rdpath
  import sdr_rdpath_pkg::*;
#(
  parameter int DQ_W    = 16,
  parameter int LANE_W  = 8,
  parameter int MIN_LAT = 2,
  parameter int MAX_LAT = 3,
  parameter int DQM_DLY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LAT_CODE_W-1:0]     lat_code,
  input  logic                      rd_issue,
  input  logic [DQ_W-1:0]           rd_word,
  input  logic                      pre_cmd,
  input  logic [DQ_W/LANE_W-1:0]    dqm,
  input  logic                      wr_beat,
  output logic [DQ_W-1:0]           dq_out,
  output logic [DQ_W/LANE_W-1:0]    dq_oe,
  output logic [DQ_W/LANE_W-1:0]    wr_lane_we,
  output logic                      lat_err
);
  localparam int LANES = DQ_W / LANE_W;
  localparam int IDX_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  logic             lat_ok;
  logic [IDX_W-1:0] tap_sel;
  logic             pipe_load;
  logic             tap_vld;
  logic [DQ_W-1:0]  tap_data;
  logic [LANES-1:0] dqm_q [DQM_DLY];
  logic [LANES-1:0] dqm_d [DQM_DLY];

  lat_decode #(.MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT), .IDX_W(IDX_W)) u_dec (
    .code    (lat_code),
    .lat_ok  (lat_ok),
    .tap_sel (tap_sel)
  );

  assign lat_err   = ~lat_ok;
  assign pipe_load = rd_issue & ~pre_cmd & lat_ok;

  rd_shift_pipe #(.DEPTH(MAX_LAT), .DW(DQ_W), .IDX_W(IDX_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pipe_load),
    .flush    (lat_err),
    .din      (rd_word),
    .tap_sel  (tap_sel),
    .out_vld  (tap_vld),
    .out_data (tap_data)
  );

  // Read-side mask delay line: fixed depth, independent of read latency.
  for (genvar s = 0; s < DQM_DLY; s++) begin : g_dqm
    if (s == 0) begin : g_first
      always_comb dqm_d[s] = dqm;
    end else begin : g_next
      always_comb dqm_d[s] = dqm_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dqm_q[s] <= '0;
      else        dqm_q[s] <= dqm_d[s];
    end
  end

  lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .rd_vld     (tap_vld & lat_ok),
    .rd_data    (tap_data),
    .dqm_late   (dqm_q[DQM_DLY-1]),
    .wr_beat    (wr_beat),
    .dqm_now    (dqm),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .wr_lane_we (wr_lane_we)
  );
endmodule

// File: rtl/sdr_rdpath_chk.sv
module sdr_rdpath_chk #(
  parameter int DQ_W   = 16,
  parameter int LANE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             lat_code,
  input logic                   rd_issue,
  input logic                   pre_cmd,
  input logic [DQ_W/LANE_W-1:0] dqm,
  input logic                   wr_beat,
  input logic [DQ_W-1:0]        dq_out,
  input logic [DQ_W/LANE_W-1:0] dq_oe,
  input logic [DQ_W/LANE_W-1:0] wr_lane_we,
  input logic                   lat_err
);
  localparam int LANES = DQ_W / LANE_W;

  logic [LANES-1:0] m_p1, m_p2;
  logic [2:0]       ld_h;
  logic             ld_now;
  logic             ld_at_lat;

  assign ld_now    = rd_issue & ~pre_cmd & ~lat_err;
  assign ld_at_lat = (lat_code == 3'b010) ? ld_h[1] : ld_h[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= '0;
      m_p2 <= '0;
      ld_h <= '0;
    end else begin
      m_p1 <= dqm;
      m_p2 <= m_p1;
      ld_h <= {ld_h[1:0], ld_now};
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lat_err |-> (dq_oe == '0)); // R7

  AST_RD_MASK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe & m_p2) == '0); // R4

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ld_at_lat); // R2

  AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_we & dqm) == '0); // R5

  AST_WR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_beat |-> (wr_lane_we == '0)); // R5

  for (genvar b = 0; b < LANES; b++) begin : g_zero
    AST_OFF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[b] |-> (dq_out[b*LANE_W +: LANE_W] == '0)); // R8
  end
endmodule

bind sdr_rdpath sdr_rdpath_chk #(.DQ_W(DQ_W), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lat_code   (lat_code),
  .rd_issue   (rd_issue),
  .pre_cmd    (pre_cmd),
  .dqm        (dqm),
  .wr_beat    (wr_beat),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .wr_lane_we (wr_lane_we),
  .lat_err    (lat_err)
);

// File: tb/sdr_rdpath_tb.sv
module sdr_rdpath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lat_code = 3'b011;
  logic        rd_issue = 1'b0;
  logic [15:0] rd_word = '0;
  logic        pre_cmd = 1'b0;
  logic [1:0]  dqm = '0;
  logic        wr_beat = 1'b0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [1:0]  wr_lane_we;
  logic        lat_err;

  always #4 clk = ~clk;

  sdr_rdpath dut_i (
    .clk(clk), .rst_n(rst_n), .lat_code(lat_code), .rd_issue(rd_issue),
    .rd_word(rd_word), .pre_cmd(pre_cmd), .dqm(dqm), .wr_beat(wr_beat),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_lane_we(wr_lane_we), .lat_err(lat_err)
  );

  localparam int HMAX = 4096;
  logic        rd_h   [HMAX];
  logic        pre_h  [HMAX];
  logic [15:0] word_h [HMAX];
  logic [1:0]  dqm_h  [HMAX];
  logic [2:0]  code_h [HMAX];

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R2";

  function automatic bit code_ok(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

  // Index of the read whose slot is cycle c, or -1 when the slot is empty.
  function automatic int src_of(input int c);
    int L, r;
    if (!code_ok(code_h[c])) return -1;
    L = (code_h[c] == 3'b010) ? 2 : 3;
    r = c - L;
    if (r < 0) return -1;
    if (!rd_h[r] || pre_h[r]) return -1;
    for (int x = r; x < c; x++) if (!code_ok(code_h[x])) return -1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [15:0] w, input logic p,
                      input logic [1:0] m, input logic wb, input logic [2:0] code);
    int          src;
    logic [1:0]  e_oe;
    logic [15:0] e_dq;
    @(negedge clk);
    rd_issue = r; rd_word = w; pre_cmd = p; dqm = m; wr_beat = wb; lat_code = code;
    rd_h[cyc] = r; word_h[cyc] = w; pre_h[cyc] = p; dqm_h[cyc] = m; code_h[cyc] = code;
    #1;
    src  = src_of(cyc);
    e_oe = (src >= 0) ? 2'b11 : 2'b00;
    if (cyc >= 2) e_oe = e_oe & ~dqm_h[cyc-2];
    e_dq = 16'h0000;
    if (e_oe[0]) e_dq[7:0]  = word_h[src][7:0];
    if (e_oe[1]) e_dq[15:8] = word_h[src][15:8];
    chk("R1", {15'b0, lat_err}, {15'b0, !code_ok(code)});
    chk(cur_req, {14'b0, dq_oe}, {14'b0, e_oe});
    chk((e_oe == 2'b00) ? "R8" : cur_req, dq_out, e_dq);
    chk("R5", {14'b0, wr_lane_we}, {14'b0, (wb ? ~m : 2'b00)});
    cyc++;
  endtask

  task automatic idle(input int n, input logic [2:0] code);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b0, 2'b00, 1'b0, code);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'd5813));
    // R9: reset state
    repeat (2) begin
      @(negedge clk);
      #1;
      chk("R9", {14'b0, dq_oe}, 16'h0);
      chk("R9", dq_out, 16'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R9";
    idle(1, 3'b011);

    // R2: single reads at both latencies
    cur_req = "R2";
    step(1'b1, 16'hA55A, 1'b0, 2'b00, 1'b0, 3'b011);
    idle(4, 3'b011);
    idle(2, 3'b010);
    step(1'b1, 16'h1234, 1'b0, 2'b00, 1'b0, 3'b010);
    idle(4, 3'b010);

    // R3: consecutive reads stream out in order
    cur_req = "R3";
    for (int i = 0; i < 6; i++) step(1'b1, 16'h3000 + 16'(i), 1'b0, 2'b00, 1'b0, 3'b011);
    idle(4, 3'b011);
    for (int i = 0; i < 6; i++) step(1'b1, 16'h2000 + 16'(i), 1'b0, 2'b00, 1'b0, 3'b010);
    idle(4, 3'b010);

    // R4: per-lane mask on reads with a two-clock delay
    cur_req = "R4";
    step(1'b1, 16'hC3C3, 1'b0, 2'b00, 1'b0, 3'b011);
    step(1'b1, 16'hD4D4, 1'b0, 2'b01, 1'b0, 3'b011);
    step(1'b1, 16'hE5E5, 1'b0, 2'b10, 1'b0, 3'b011);
    step(1'b1, 16'hF6F6, 1'b0, 2'b11, 1'b0, 3'b011);
    step(1'b1, 16'h0707, 1'b0, 2'b00, 1'b0, 3'b011);
    idle(4, 3'b011);

    // R5: write strobes follow mask in the same cycle
    cur_req = "R5";
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0, 2'(i), 1'b1, 3'b011);

    // R6: precharge cut at p+L for both latencies
    cur_req = "R6";
    step(1'b1, 16'h6161, 1'b0, 2'b00, 1'b0, 3'b011);
    step(1'b1, 16'h6262, 1'b1, 2'b00, 1'b0, 3'b011);
    idle(4, 3'b011);
    idle(1, 3'b010);
    step(1'b1, 16'h6363, 1'b0, 2'b00, 1'b0, 3'b010);
    step(1'b1, 16'h6464, 1'b1, 2'b00, 1'b0, 3'b010);
    idle(4, 3'b010);

    // R7: reserved codes flush and silence the pipeline
    cur_req = "R7";
    step(1'b1, 16'h7171, 1'b0, 2'b00, 1'b0, 3'b011);
    step(1'b1, 16'h7272, 1'b0, 2'b00, 1'b0, 3'b011);
    step(1'b1, 16'h7373, 1'b0, 2'b00, 1'b0, 3'b000);
    step(1'b1, 16'h7474, 1'b0, 2'b00, 1'b0, 3'b111);
    idle(5, 3'b011);
    step(1'b1, 16'h7575, 1'b0, 2'b00, 1'b0, 3'b010);
    step(1'b1, 16'h7676, 1'b0, 2'b00, 1'b0, 3'b001);
    idle(5, 3'b010);

    // Random mix, seeded
    cur_req = "R2";
    begin
      logic [2:0] code;
      code = 3'b011;
      for (int i = 0; i < 2000; i++) begin
        if (i % 40 == 0) begin
          case ($urandom_range(0, 5))
            0, 1: code = 3'b010;
            2, 3: code = 3'b011;
            4:    code = 3'b001;
            default: code = 3'b100;
          endcase
        end
        step(($urandom_range(0, 9) < 6), 16'($urandom), ($urandom_range(0, 9) == 0),
             2'($urandom_range(0, 3) == 0 ? $urandom_range(1, 3) : 0),
             1'($urandom_range(0, 1)), code);
      end
    end
    finish_run();
  end
endmodule